// File: doc/BRIEF.md
# Leaf Page-Entry Permission Checker with Reference/Change Update

This block sits behind a radix table walker. It takes the leaf page-table entry that the walker fetched, the memory address the entry came from, the kind of access (read, write or execute), whether the core runs in problem (user) state, and a 3-bit permission set from the authority mask. From these it works out which permissions the access is granted and whether the access faults. A guarded-I/O execute block takes priority over every other check.

When the access is allowed, the block sets the reference bit and, on a store, the change bit. It writes the entry back through a single-beat write port, and only when the value has actually changed. On loads and fetches it removes write permission from the reported grant. A later store then comes back through the block and has the change bit written. Each request ends with a one-cycle done strobe. The granted set and the fault flags are valid from that strobe until the next request.

Top module: `pte_guard`

## Requirements
- R1: An execute access (`acc_type` 2) to an entry whose attribute field, bits 5:4, equals 2'b11 raises `fault_guard`. It does not raise `fault_prot`, whatever the permission bits say. The same attribute does not fault read or write accesses.
- R2: If privilege bit 3 of the entry is set and `problem_state` is 1, the granted set is empty, so every access type raises `fault_prot`.
- R3: In problem state on a non-privileged entry, and in either state on a privileged entry, the permissions come only from the entry's authority bits: bit 2 read, bit 1 write, bit 0 execute. `amr_perm` has no effect.
- R4: In privileged state (`problem_state` 0) on a non-privileged entry, the permissions are the entry's authority bits ANDed with `amr_perm`, which uses the same bit order (2 read, 1 write, 0 execute).
- R5: Access encodings are 0 read, 1 write, 2 execute, and 3 is treated as read. When the permission the access needs is missing from the set, `fault_prot` is raised.
- R6: On a successful access the updated entry has reference bit 8 set. Change bit 7 is set only for a write. All other bits are unchanged.
- R7: On a successful non-write access, the reported `grant_perm` has the write bit (bit 1) cleared. On a successful write, the set is reported unchanged.
- R8: The updated entry is written only if it differs from the fetched one. The write goes to `pte_addr` with the updated value. `wr_en` stays high with stable address and data until a cycle in which `wr_ack` is high.
- R9: A faulting access performs no write. It reports `grant_perm` 0 and at most one fault flag.
- R10: `done` is a single-cycle pulse. Counting the edge that accepts `req_valid` as edge 0, it is high in the cycle after edge 1 when no write is needed. Otherwise it is high in the cycle after the edge that samples `wr_ack`.
- R11: `req_valid` is ignored while a request is in progress. It starts no second request and does not change the reported results.
- R12: After reset, `done`, `wr_en`, both fault flags and `grant_perm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a check; accepted only when idle |
| pte | input | PTE_W | Fetched leaf entry |
| pte_addr | input | ADDR_W | Memory address of the entry |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| problem_state | input | 1 | 1 when the access is made in user state |
| amr_perm | input | 3 | Authority-mask permissions {read, write, execute} |
| wr_en | output | 1 | Write request for the updated entry, held until acknowledged |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | PTE_W | Updated entry |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle completion strobe |
| grant_perm | output | 3 | Granted {read, write, execute} |
| fault_guard | output | 1 | Execute on guarded non-idempotent I/O |
| fault_prot | output | 1 | Needed permission not granted |

## Verification
A wrong decision in the permission logic shows up at `fault_prot`, `fault_guard` or `grant_perm` at the very next `done`, two cycles after the request. A wrong merge of the reference and change bits shows up at `wr_data` as soon as `wr_en` rises, or as a write that appears or fails to appear, which also moves `done` later or earlier by at least one cycle. A control state that fails to return to idle shows up as a missing or repeated `done`, or as a second request being accepted while busy.

// File: rtl/pte_guard_pkg.sv
package pte_guard_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  localparam int REF_POS  = 8;
  localparam int CHG_POS  = 7;
  localparam int ATT_HI   = 5;
  localparam int ATT_LO   = 4;
  localparam int PRIV_POS = 3;
  localparam int RD_POS   = 2;
  localparam int WR_POS   = 1;
  localparam int EX_POS   = 0;
  localparam logic [ATT_HI-ATT_LO:0] ATT_NIO = 2'b11;

  // Permission an access of the given kind needs
  function automatic perm_t need_of(input acc_kind_e k);
    perm_t n;
    n = '0;
    case (k)
      ACC_WRITE: n.wr = 1'b1;
      ACC_EXEC:  n.ex = 1'b1;
      default:   n.rd = 1'b1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
  import pte_guard_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] entry,
  input  acc_kind_e        kind,
  input  logic             user_mode,
  input  perm_t            mask_perm,
  output perm_t            allowed,
  output logic             guard_hit,
  output logic             prot_hit
);

  perm_t eaa;
  perm_t need;
  logic  priv_pg;
  logic  nio;

  always_comb begin
    eaa     = perm_t'({entry[RD_POS], entry[WR_POS], entry[EX_POS]});
    priv_pg = entry[PRIV_POS];
    nio     = (entry[ATT_HI:ATT_LO] == ATT_NIO);
    need    = need_of(kind);

    if (priv_pg && user_mode) begin
      allowed = '0;
    end else if (user_mode || priv_pg) begin
      allowed = eaa;
    end else begin
      allowed = eaa & mask_perm;
    end

    guard_hit = nio && (kind == ACC_EXEC);
    prot_hit  = !guard_hit && ((need & ~allowed) != '0);
  end

endmodule

// File: rtl/pte_rc_merge.sv
module pte_rc_merge
  import pte_guard_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] old_entry,
  input  logic             is_store,
  output logic [PTE_W-1:0] new_entry,
  output logic             differs
);

  always_comb begin
    new_entry          = old_entry;
    new_entry[REF_POS] = 1'b1;
    if (is_store) begin
      new_entry[CHG_POS] = 1'b1;
    end
    differs = (new_entry != old_entry);
  end

endmodule

// File: rtl/pte_guard.sv
module pte_guard
  import pte_guard_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PTE_W-1:0]  pte,
  input  logic [ADDR_W-1:0] pte_addr,
  input  logic [1:0]        acc_type,
  input  logic              problem_state,
  input  logic [2:0]        amr_perm,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PTE_W-1:0]  wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic [2:0]        grant_perm,
  output logic              fault_guard,
  output logic              fault_prot
);

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_WRITE} st_e;

  st_e               state;
  logic [PTE_W-1:0]  c_pte;
  logic [ADDR_W-1:0] c_addr;
  acc_kind_e         c_kind;
  logic              c_user;
  perm_t             c_mask;

  perm_t             allowed;
  logic              guard_hit;
  logic              prot_hit;
  logic [PTE_W-1:0]  merged;
  logic              differs;
  logic              is_store;
  perm_t             reported;

  assign is_store = (c_kind == ACC_WRITE);

  pte_perm_eval #(.PTE_W(PTE_W)) u_eval (
    .entry     (c_pte),
    .kind      (c_kind),
    .user_mode (c_user),
    .mask_perm (c_mask),
    .allowed   (allowed),
    .guard_hit (guard_hit),
    .prot_hit  (prot_hit)
  );

  pte_rc_merge #(.PTE_W(PTE_W)) u_merge (
    .old_entry (c_pte),
    .is_store  (is_store),
    .new_entry (merged),
    .differs   (differs)
  );

  always_comb begin
    reported = allowed;
    if (!is_store) begin
      reported.wr = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      c_pte       <= '0;
      c_addr      <= '0;
      c_kind      <= ACC_READ;
      c_user      <= 1'b0;
      c_mask      <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      done        <= 1'b0;
      grant_perm  <= '0;
      fault_guard <= 1'b0;
      fault_prot  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            c_pte  <= pte;
            c_addr <= pte_addr;
            c_kind <= acc_kind_e'(acc_type);
            c_user <= problem_state;
            c_mask <= perm_t'(amr_perm);
            state  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (guard_hit || prot_hit) begin
            grant_perm  <= '0;
            fault_guard <= guard_hit;
            fault_prot  <= prot_hit;
            done        <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            grant_perm  <= reported;
            fault_guard <= 1'b0;
            fault_prot  <= 1'b0;
            if (differs) begin
              wr_en   <= 1'b1;
              wr_addr <= c_addr;
              wr_data <= merged;
              state   <= ST_WRITE;
            end else begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        ST_WRITE: begin
          if (wr_ack) begin
            wr_en <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pte_guard_chk.sv
module pte_guard_chk
  import pte_guard_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PTE_W-1:0]  wr_data,
  input logic              wr_ack,
  input logic              done,
  input logic [2:0]        grant_perm,
  input logic              fault_guard,
  input logic              fault_prot
);

  // R10: completion strobe lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: write request held steady until acknowledged
  assert_write_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ack) |=> (wr_en && $stable(wr_data) && $stable(wr_addr)));

  // R6: every written entry carries the reference bit
  assert_ref_written_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_data[REF_POS]);

  // R9: fault flags never both high
  assert_fault_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fault_guard, fault_prot}));

  // R9: a faulting completion grants nothing and was not preceded by a write
  assert_fault_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
    (done && (fault_guard || fault_prot)) |-> (grant_perm == 3'b000 && !wr_en && !$past(wr_en)));

  // R10: done only after the write port has been released
  assert_done_no_wr_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);

endmodule

bind pte_guard pte_guard_chk #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .wr_ack      (wr_ack),
  .done        (done),
  .grant_perm  (grant_perm),
  .fault_guard (fault_guard),
  .fault_prot  (fault_prot)
);

// File: tb/tb_pte_guard.sv
`timescale 1ns/1ps
module tb_pte_guard;

  localparam int PW = 64;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [PW-1:0] pte = '0;
  logic [AW-1:0] pte_addr = '0;
  logic [1:0]    acc_type = '0;
  logic          problem_state = 1'b0;
  logic [2:0]    amr_perm = '0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] wr_data;
  logic          wr_ack = 1'b0;
  logic          done;
  logic [2:0]    grant_perm;
  logic          fault_guard;
  logic          fault_prot;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  pte_guard #(.PTE_W(PW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .pte(pte), .pte_addr(pte_addr),
    .acc_type(acc_type), .problem_state(problem_state), .amr_perm(amr_perm),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .grant_perm(grant_perm), .fault_guard(fault_guard), .fault_prot(fault_prot)
  );

  // observed results of the last access
  logic [2:0]    o_grant;
  logic          o_guard, o_prot;
  int            o_writes, o_lat;
  logic [AW-1:0] o_waddr;
  logic [PW-1:0] o_wdata;

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] mk(input logic [1:0] att, input logic priv,
                                      input logic [2:0] eaa, input logic r, input logic c);
    logic [PW-1:0] v;
    v = 64'hA5A0_0000_0000_0000;
    v[5:4] = att; v[3] = priv; v[2:0] = eaa; v[8] = r; v[7] = c;
    return v;
  endfunction

  // independent model of the requirements
  task automatic model(input logic [PW-1:0] p, input logic [1:0] acc, input logic pr,
                       input logic [2:0] amr, output logic [2:0] g, output logic gf,
                       output logic pf, output logic wr, output logic [PW-1:0] nd);
    logic [2:0] perm, need;
    gf = (p[5:4] == 2'b11) && (acc == 2'd2);
    if (p[3] && pr) perm = 3'b000;
    else if (pr || p[3]) perm = p[2:0];
    else perm = p[2:0] & amr;
    need = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b001 : 3'b100;
    pf = !gf && ((need & ~perm) != 0);
    nd = p; nd[8] = 1'b1; if (acc == 2'd1) nd[7] = 1'b1;
    wr = !gf && !pf && (nd != p);
    if (gf || pf) g = 3'b000;
    else g = (acc == 2'd1) ? perm : (perm & 3'b101);
  endtask

  task automatic run_access(input logic [PW-1:0] p, input logic [AW-1:0] a, input logic [1:0] acc,
                            input logic pr, input logic [2:0] amr, input int dly, input bit poke);
    int cnt;
    bit poked;
    @(negedge clk);
    pte = p; pte_addr = a; acc_type = acc; problem_state = pr; amr_perm = amr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    o_lat = 1; o_writes = 0; cnt = dly; poked = 0;
    o_waddr = '0; o_wdata = '0;
    while (!done && o_lat < 60) begin
      if (poke && poked) req_valid = 1'b0;
      if (wr_en && !wr_ack) begin
        o_waddr = wr_addr; o_wdata = wr_data;
        if (poke && !poked) begin
          pte = mk(2'b11, 1'b0, 3'b000, 1'b0, 1'b0); acc_type = 2'd2;
          req_valid = 1'b1; poked = 1;
        end
        if (cnt == 0) begin wr_ack = 1'b1; o_writes++; end
        else cnt--;
      end
      @(negedge clk);
      o_lat++;
    end
    wr_ack = 1'b0; req_valid = 1'b0;
    o_grant = grant_perm; o_guard = fault_guard; o_prot = fault_prot;
  endtask

  task automatic scenario(input string req, input logic [PW-1:0] p, input logic [1:0] acc,
                          input logic pr, input logic [2:0] amr, input int dly);
    logic [2:0] g; logic gf, pf, wr; logic [PW-1:0] nd;
    logic [AW-1:0] a;
    a = 48'h1234_5678_0000 + {38'd0, p[9:0]};
    model(p, acc, pr, amr, g, gf, pf, wr, nd);
    run_access(p, a, acc, pr, amr, dly, 1'b0);
    check({req, " grant"}, 64'(o_grant), 64'(g));
    check({req, " fault_guard"}, 64'(o_guard), 64'(gf));
    check({req, " fault_prot"}, 64'(o_prot), 64'(pf));
    check({req, " write count R8"}, 64'(o_writes), 64'(wr ? 1 : 0));
    if (wr) begin
      check({req, " written data R6"}, o_wdata, nd);
      check({req, " written address R8"}, 64'(o_waddr), 64'(a));
      check({req, " latency with write R10"}, 64'(o_lat), 64'(3 + dly));
    end else begin
      check({req, " latency R10"}, 64'(o_lat), 64'd2);
    end
    @(negedge clk);
    check({req, " done single pulse R10"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    check("R12 done", 64'(done), 0);
    check("R12 wr_en", 64'(wr_en), 0);
    check("R12 faults", 64'({fault_guard, fault_prot}), 0);
    check("R12 grant", 64'(grant_perm), 0);
  endtask

  task automatic t_guard();
    scenario("R1 exec on NIO", mk(2'b11, 1'b0, 3'b111, 1'b1, 1'b0), 2'd2, 1'b0, 3'b111, 0);
    scenario("R1 exec on NIO no perms", mk(2'b11, 1'b0, 3'b000, 1'b0, 1'b0), 2'd2, 1'b1, 3'b000, 0);
    scenario("R1 read on NIO", mk(2'b11, 1'b0, 3'b100, 1'b0, 1'b0), 2'd0, 1'b1, 3'b000, 0);
    scenario("R1 exec on other attr", mk(2'b10, 1'b0, 3'b001, 1'b1, 1'b0), 2'd2, 1'b1, 3'b000, 0);
  endtask

  task automatic t_priv();
    scenario("R2 priv page user read", mk(2'b00, 1'b1, 3'b111, 1'b1, 1'b1), 2'd0, 1'b1, 3'b111, 0);
    scenario("R2 priv page user write", mk(2'b00, 1'b1, 3'b111, 1'b1, 1'b1), 2'd1, 1'b1, 3'b111, 0);
    scenario("R3 priv page kernel amr ignored", mk(2'b00, 1'b1, 3'b110, 1'b0, 1'b0), 2'd1, 1'b0, 3'b000, 1);
    scenario("R3 user nonpriv amr ignored", mk(2'b00, 1'b0, 3'b101, 1'b0, 1'b0), 2'd2, 1'b1, 3'b000, 0);
  endtask

  task automatic t_amr();
    scenario("R4 kernel amr allows", mk(2'b00, 1'b0, 3'b111, 1'b0, 1'b0), 2'd1, 1'b0, 3'b010, 2);
    scenario("R4 kernel amr denies", mk(2'b00, 1'b0, 3'b111, 1'b1, 1'b1), 2'd0, 1'b0, 3'b011, 0);
    scenario("R5 write without perm", mk(2'b01, 1'b0, 3'b101, 1'b0, 1'b0), 2'd1, 1'b1, 3'b111, 0);
    scenario("R5 code 3 as read", mk(2'b00, 1'b0, 3'b100, 1'b0, 1'b1), 2'd3, 1'b1, 3'b000, 0);
    scenario("R5 code 3 no read perm", mk(2'b00, 1'b0, 3'b011, 1'b0, 1'b0), 2'd3, 1'b1, 3'b000, 0);
  endtask

  task automatic t_rc();
    scenario("R7 read clears W R already set", mk(2'b00, 1'b0, 3'b111, 1'b1, 1'b0), 2'd0, 1'b1, 3'b000, 0);
    scenario("R6 write sets R and C", mk(2'b00, 1'b0, 3'b010, 1'b0, 1'b0), 2'd1, 1'b1, 3'b000, 4);
    scenario("R8 write with R C set no writeback", mk(2'b00, 1'b0, 3'b110, 1'b1, 1'b1), 2'd1, 1'b1, 3'b000, 0);
    scenario("R6 write with R set only", mk(2'b00, 1'b0, 3'b010, 1'b1, 1'b0), 2'd1, 1'b1, 3'b000, 0);
    scenario("R7 exec keeps X drops W", mk(2'b00, 1'b0, 3'b011, 1'b0, 1'b1), 2'd2, 1'b1, 3'b000, 0);
  endtask

  task automatic t_busy();
    logic [PW-1:0] p;
    p = mk(2'b00, 1'b0, 3'b110, 1'b0, 1'b0);
    run_access(p, 48'h0000_0000_0AB8, 2'd1, 1'b1, 3'b000, 3, 1'b1);
    check("R11 grant unaffected", 64'(o_grant), 64'(3'b110));
    check("R11 no fault from ignored request", 64'({o_guard, o_prot}), 0);
    check("R11 latency unaffected", 64'(o_lat), 64'd6);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R11 no second completion", 64'(done), 0);
      check("R11 no second write", 64'(wr_en), 0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_guard();
    t_priv();
    t_amr();
    t_rc();
    t_busy();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule